// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address for every beat of one SDRAM read or write burst. A controller pulses a start strobe together with the starting column, a burst length code, a wrap-order select and a direction flag. From the next clock on, the block presents one column per cycle with a valid flag. It raises a last flag on the final beat of a finite burst, so the controller knows which data beat closes the access.

Two wrap orders are supported. Sequential order counts upward inside an aligned block the size of the burst. Interleaved order flips the low address bits according to the beat number. A full-page length walks the whole 256-column row and keeps going until a stop strobe ends it. A new start strobe always takes over at once. This is how a read that arrives during a write burst cuts that write short. Bank, row, data-pin timing and command encoding belong to the surrounding controller.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is high, and in the cycle after reset is released with no start, `valid_o` and `last_o` are 0.
- R2: The length code is sampled only at a start. 000 gives 1 beat, 001 gives 2, 010 gives 4, 011 gives 8 and 111 gives full page. The codes 100, 101 and 110 are treated as 1 beat. A start at edge t makes beat 0 visible after edge t, and a finite burst of N beats holds `valid_o` high for exactly N cycles with `last_o` high only on beat N-1. Input changes after the start strobe do not alter the burst.
- R3: In sequential order, beat k has column `S - (S mod N) + ((S mod N + k) mod N)`, where S is the start column and N is the burst length.
- R4: In interleaved order (`ilv_i`=1), beat k has column `S XOR k`.
- R5: A full-page burst gives beat k the column `(S + k) mod 256`, never raises `last_o`, and stays valid until it is stopped.
- R6: Interleaved order combined with full page behaves exactly like sequential full page.
- R7: When `stop_i` is high at an edge with no start during a burst, `valid_o` is 0 after that edge. When the block is idle, `stop_i` has no effect.
- R8: A start during an active burst restarts the block. After that edge the output is beat 0 of the new burst, with the new column, length and order. A start wins over a stop at the same edge.
- R9: `wr_o` shows the direction flag latched at the start of the current burst. A read start (`wr_i`=0) during a write burst ends the write at that edge, and the next cycle shows the read's first column with `wr_o`=0.
- R10: A length-1 burst shows a single beat with both `valid_o` and `last_o` high, and `valid_o` is 0 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe for a new burst |
| start_col_i | input | 8 | Starting column |
| len_code_i | input | 3 | Burst length code |
| ilv_i | input | 1 | 1 = interleaved order, 0 = sequential |
| wr_i | input | 1 | 1 = write burst, 0 = read burst |
| stop_i | input | 1 | Burst stop strobe |
| col_o | output | 8 | Column address of the current beat |
| valid_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | Current beat is the final one of a finite burst |
| wr_o | output | 1 | Direction of the burst in progress |

## Verification
The hardest situations to reach are the interactions of a running burst with a new strobe. These are a restart partway through a burst with a different order and length, a read that cuts into a write, and a start and a stop arriving on the same edge. Reaching them means holding a burst open for a chosen number of beats and then firing the second strobe on an exact cycle. Directed sequences do that after a vector table has covered the length codes, both orders and the wrap corners near the top of the row. A full-page run of 300 beats crosses the 255-to-0 wrap before it is stopped.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

    localparam int COL_W   = 8;
    localparam int LCODE_W = 3;
    localparam int MAX_LOG = 3;

    typedef enum logic [LCODE_W-1:0] {
        BL_ONE  = 3'b000,
        BL_TWO  = 3'b001,
        BL_FOUR = 3'b010,
        BL_EIGHT= 3'b011,
        BL_PAGE = 3'b111
    } blen_e;

    // decoded burst settings captured at a start strobe
    typedef struct packed {
        logic [COL_W-1:0] mask;   // burst length minus one
        logic             page;   // runs until stopped
        logic             ilv;    // effective interleaved order
    } bcfg_t;

    // beat-counter and context state
    typedef struct packed {
        logic             busy;
        logic [COL_W-1:0] cnt;
        logic [COL_W-1:0] base;
        logic             wr;
        bcfg_t            cfg;
    } bstate_t;

    function automatic logic [COL_W-1:0] code_to_mask(input logic [LCODE_W-1:0] code);
        logic [COL_W-1:0] m;
        m = '0;
        if (code == BL_PAGE) begin
            m = '1;
        end else if (int'(code) <= MAX_LOG) begin
            for (int i = 0; i < COL_W; i++) begin
                if (i < int'(code)) m[i] = 1'b1;
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/bcg_cfg_decode.sv
module bcg_cfg_decode
    import bcg_pkg::*;
#(
    parameter int LW = LCODE_W
) (
    input  logic [LW-1:0] len_code,
    input  logic          ilv_req,
    output bcfg_t         cfg
);
    logic is_page;

    always_comb begin
        is_page  = (len_code == BL_PAGE);
        cfg.mask = code_to_mask(len_code);
        cfg.page = is_page;
        // interleaved order is meaningless across a full row
        cfg.ilv  = ilv_req & ~is_page;
    end
endmodule

// File: rtl/bcg_beat_ctrl.sv
module bcg_beat_ctrl
    import bcg_pkg::*;
#(
    parameter int CW = COL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          stop,
    input  logic [CW-1:0] col_in,
    input  logic          wr_in,
    input  bcfg_t         cfg_in,
    output bstate_t       st,
    output logic          final_beat
);
    bstate_t st_q;

    assign final_beat = st_q.busy & ~st_q.cfg.page & (st_q.cnt == st_q.cfg.mask);
    assign st         = st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.busy <= 1'b0;
            st_q.cnt  <= '0;
            st_q.base <= '0;
            st_q.wr   <= 1'b0;
            st_q.cfg  <= '0;
        end else if (start) begin
            st_q.busy <= 1'b1;
            st_q.cnt  <= '0;
            st_q.base <= col_in;
            st_q.wr   <= wr_in;
            st_q.cfg  <= cfg_in;
        end else if (st_q.busy) begin
            if (stop || final_beat) begin
                st_q.busy <= 1'b0;
            end else begin
                st_q.cnt  <= st_q.cnt + 1'b1;
            end
        end
    end

    // R7
    stop_ends_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.busy && stop && !start |=> !st_q.busy);

    // R8
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> st_q.busy && st_q.cnt == '0);

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.busy && !st_q.cfg.page |-> st_q.cnt <= st_q.cfg.mask);

    // R5
    page_runs_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.busy && st_q.cfg.page && !stop && !start |=> st_q.busy);
endmodule

// File: rtl/bcg_addr_gen.sv
module bcg_addr_gen
    import bcg_pkg::*;
#(
    parameter int CW = COL_W
) (
    input  logic [CW-1:0] base,
    input  logic [CW-1:0] cnt,
    input  bcfg_t         cfg,
    output logic [CW-1:0] col
);
    logic [CW-1:0] sum;

    assign sum = base + cnt;

    for (genvar b = 0; b < CW; b++) begin : g_bit
        always_comb begin
            if (!cfg.mask[b])
                col[b] = base[b];
            else if (cfg.ilv)
                col[b] = base[b] ^ cnt[b];
            else
                col[b] = sum[b];
        end
    end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import bcg_pkg::*;
#(
    parameter int CW = COL_W,
    parameter int LW = LCODE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [CW-1:0] start_col_i,
    input  logic [LW-1:0] len_code_i,
    input  logic          ilv_i,
    input  logic          wr_i,
    input  logic          stop_i,
    output logic [CW-1:0] col_o,
    output logic          valid_o,
    output logic          last_o,
    output logic          wr_o
);
    bcfg_t   cfg_new;
    bstate_t st;
    logic    fin;

    bcg_cfg_decode #(.LW(LW)) u_dec (
        .len_code (len_code_i),
        .ilv_req  (ilv_i),
        .cfg      (cfg_new)
    );

    bcg_beat_ctrl #(.CW(CW)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start_i),
        .stop       (stop_i),
        .col_in     (start_col_i),
        .wr_in      (wr_i),
        .cfg_in     (cfg_new),
        .st         (st),
        .final_beat (fin)
    );

    bcg_addr_gen #(.CW(CW)) u_addr (
        .base (st.base),
        .cnt  (st.cnt),
        .cfg  (st.cfg),
        .col  (col_o)
    );

    assign valid_o = st.busy;
    assign last_o  = fin;
    assign wr_o    = st.wr;

    // R2
    last_valid_chk: assert property (@(posedge clk) disable iff (rst)
        last_o |-> valid_o);

    // R8
    first_col_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> valid_o && col_o == $past(start_col_i));

    // R9
    wr_follow_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> wr_o == $past(wr_i));

    // R10
    single_end_chk: assert property (@(posedge clk) disable iff (rst)
        last_o && !start_i |=> !valid_o);
endmodule

// File: tb/tb_burst_col_gen.sv
module tb_burst_col_gen;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 150000;
    localparam int NVEC       = 10;

    // [12:5] start column, [4:2] length code, [1] interleaved, [0] write
    localparam logic [12:0] VEC [NVEC] = '{
        {8'h00, 3'd0, 1'b0, 1'b0},
        {8'h05, 3'd1, 1'b0, 1'b1},
        {8'h06, 3'd2, 1'b0, 1'b0},
        {8'h0D, 3'd3, 1'b0, 1'b1},
        {8'h0D, 3'd3, 1'b1, 1'b0},
        {8'h2B, 3'd2, 1'b1, 1'b1},
        {8'hFF, 3'd3, 1'b0, 1'b0},
        {8'h81, 3'd5, 1'b0, 1'b0},
        {8'h77, 3'd1, 1'b1, 1'b0},
        {8'hF3, 3'd6, 1'b1, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [7:0] start_col_i = '0;
    logic [2:0] len_code_i = '0;
    logic       ilv_i = 1'b0;
    logic       wr_i = 1'b0;
    logic       stop_i = 1'b0;
    logic [7:0] col_o;
    logic       valid_o, last_o, wr_o;

    int vectors = 0;
    int miscompares = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_col_gen dut (
        .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
        .len_code_i(len_code_i), .ilv_i(ilv_i), .wr_i(wr_i), .stop_i(stop_i),
        .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .wr_o(wr_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int beats_of(input logic [2:0] code);
        case (code)
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 8;
            3'd7: return 256;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_col(input int s, input logic [2:0] code, input logic il, input int k);
        int n;
        n = beats_of(code);
        if (code == 3'd7) return (s + k) % 256;
        if (il) return s ^ k;
        return (s - (s % n)) + (((s % n) + k) % n);
    endfunction

    task automatic launch(input logic [7:0] s, input logic [2:0] code, input logic il, input logic w);
        start_col_i = s; len_code_i = code; ilv_i = il; wr_i = w; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        // scrambled inputs must not disturb the running burst (R2)
        start_col_i = ~s; len_code_i = 3'd7; ilv_i = ~il; wr_i = ~w;
    endtask

    task automatic observe(input logic [7:0] s, input logic [2:0] code, input logic il, input logic w);
        int n;
        string rq;
        n = beats_of(code);
        rq = (n == 1) ? "R10" : (il ? "R4" : "R3");
        for (int k = 0; k < n; k++) begin
            chk(rq, "col", int'(col_o), exp_col(int'(s), code, il, k));
            chk("R2", "valid", int'(valid_o), 1);
            chk("R2", "last", int'(last_o), (k == n - 1) ? 1 : 0);
            chk("R9", "wr", int'(wr_o), int'(w));
            @(negedge clk);
        end
        chk("R2", "valid after burst", int'(valid_o), 0);
    endtask

    initial begin : wd
        repeat (WD_CYCLES) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL watchdog expired: actual running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        chk("R1", "valid in reset", int'(valid_o), 0);
        chk("R1", "last in reset", int'(last_o), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "valid after reset", int'(valid_o), 0);

        for (int v = 0; v < NVEC; v++) begin
            launch(VEC[v][12:5], VEC[v][4:2], VEC[v][1], VEC[v][0]);
            observe(VEC[v][12:5], VEC[v][4:2], VEC[v][1], VEC[v][0]);
        end

        // R5 and R6: interleaved full page wraps like sequential, stopped after 300 beats
        launch(8'hFA, 3'd7, 1'b1, 1'b0);
        for (int k = 0; k < 300; k++) begin
            chk("R6", "page col", int'(col_o), (250 + k) % 256);
            chk("R5", "page valid", int'(valid_o), 1);
            chk("R5", "page last", int'(last_o), 0);
            if (k == 299) stop_i = 1'b1;
            @(negedge clk);
        end
        stop_i = 1'b0;
        chk("R5", "page stopped", int'(valid_o), 0);

        // R7: stop in the middle of an 8-beat burst
        launch(8'h13, 3'd3, 1'b0, 1'b0);
        @(negedge clk); @(negedge clk); @(negedge clk);
        chk("R7", "beat3 col", int'(col_o), 8'h16);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        chk("R7", "valid after stop", int'(valid_o), 0);

        // R7: stop while idle has no effect, next burst runs normally
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        chk("R7", "idle stop valid", int'(valid_o), 0);
        launch(8'h42, 3'd1, 1'b0, 1'b0);
        observe(8'h42, 3'd1, 1'b0, 1'b0);

        // R8: restart with a new column, length and order
        launch(8'h40, 3'd3, 1'b0, 1'b1);
        @(negedge clk);
        chk("R8", "pre-restart col", int'(col_o), 8'h41);
        launch(8'h85, 3'd2, 1'b1, 1'b1);
        observe(8'h85, 3'd2, 1'b1, 1'b1);

        // R9: a read start cuts a write burst short
        launch(8'h10, 3'd3, 1'b0, 1'b1);
        @(negedge clk);
        chk("R9", "write running", int'(wr_o), 1);
        launch(8'h30, 3'd2, 1'b0, 1'b0);
        chk("R9", "read takes over wr", int'(wr_o), 0);
        chk("R9", "read takes over col", int'(col_o), 8'h30);
        observe(8'h30, 3'd2, 1'b0, 1'b0);

        // R8: start and stop on the same edge, start wins
        stop_i = 1'b1;
        launch(8'h22, 3'd1, 1'b0, 1'b0);
        stop_i = 1'b0;
        chk("R8", "start beats stop valid", int'(valid_o), 1);
        observe(8'h22, 3'd1, 1'b0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule